// File: doc/BRIEF.md
# System control coprocessor unit

This unit is the privileged control coprocessor of a MIPS-style core. Each cycle the core may present one decoded coprocessor-0 instruction word together with the value of the source general register and a valid strobe. The unit holds a bank of thirty-two 32-bit control registers. Register index 25 is routed instead to a masked performance-counter control register and to two counter registers. The unit does not make the counters count.

A valid instruction can do one of four kinds of work. It can move a value into a control register or out of one. It can evaluate a branch on the coprocessor condition register, index 21. It can return from an exception. It can enable or disable interrupts. All results come back to the pipeline in the same cycle: the read data, a branch-taken flag, a delay-slot annul flag, a redirect target with its valid flag, an exception-return pulse, an interrupt-recheck pulse and an illegal-instruction flag. State changes are committed on the next rising clock edge.

Top module: `sysctl_cop`

## Requirements
- R1: The format selector is instruction bits 25:21. Value 0 is a read, 4 is a write, 8 is a condition branch and 16 is a control operation. Any other format raises `illegal_o`.
- R2: A control operation is selected by bits 5:0. Code 0x02 (indexed TLB write) completes with no effect. Code 0x18 is exception return, 0x38 enables interrupts and 0x39 disables them. Any other code raises `illegal_o`.
- R3: A read returns the register at rd (bits 15:11) in the same cycle. With `mode64_i` high, bit 31 is copied into bits 63:32. With `mode64_i` low, bits 63:32 are zero. Operations other than a read return zero.
- R4: A write stores `gpr_i` into register rd on the rising edge that follows the valid cycle.
- R5: A write to Status (register 12) ORs the current EXL bit (bit 1) into the stored value, so a write cannot clear EXL.
- R6: Branch rt (bits 20:16) selects the test on register 21. rt=0 is taken when the register is zero. rt=1 is taken when it is nonzero. rt=2 is the likely form of the zero test. Any other rt raises `illegal_o`.
- R7: The likely branch raises `annul_o` when it is not taken. No other case raises `annul_o`.
- R8: Exception return with Status.ERL (bit 2) set redirects to register 30, clears ERL and pulses `eret_o`.
- R9: Exception return with ERL clear redirects to register 14, clears EXL and pulses `eret_o`.
- R10: Enable-interrupts sets Status bit 16 and pulses `irq_recheck_o`. Disable-interrupts clears bit 16 and does not pulse `irq_recheck_o`.
- R11: For accesses to register 25, instruction bit 0 = 0 selects the counter-control register. Bit 0 = 1 selects counter 0 or counter 1, chosen by bit 1.
- R12: A write to the counter-control register stores `gpr_i & 0x800FFBFE`, and only when bits 5:1 are all zero. With any other index in bits 5:1 the write is dropped.
- R13: Reset sets Status to 0x00000004 and clears every other register. With `valid_i` low, no output flag is raised and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | The instruction is valid this cycle |
| instr_i | input | 32 | Coprocessor-0 instruction word |
| gpr_i | input | 32 | Value of the source general register |
| mode64_i | input | 1 | The core runs in 64-bit mode |
| rd_data_o | output | 64 | Read result, extended to 64 bits |
| branch_taken_o | output | 1 | Condition branch is taken |
| annul_o | output | 1 | Delay slot is annulled (likely branch, not taken) |
| redirect_valid_o | output | 1 | `redirect_pc_o` is valid |
| redirect_pc_o | output | 32 | Exception-return target |
| eret_o | output | 1 | Return-from-exception indication |
| irq_recheck_o | output | 1 | Request to re-check pending interrupts |
| illegal_o | output | 1 | Illegal instruction |

## Verification
Some properties are checked on every cycle:
- A Status write never clears EXL.
- Each branch of exception return clears the right mode bit.
- The recheck pulse appears only for enable-interrupts, and EIE is set after it.
- Annul never comes with a taken branch.
- The result flags are mutually exclusive and silent while `valid_i` is low.
- The upper read bits are zero in 32-bit mode.

Only the bench scenarios can show the values that move through the registers. These are the redirect targets taken from registers 14 and 30, and the masked counter-control value. They also include the dropped write with a nonzero index, the routing of the counter index and the branch outcomes after register 21 changes.

// File: rtl/sysctl_pkg.sv
// Shared constants and types for the system control coprocessor.
// Assumes a 32-bit control register width and a 32-entry bank.
package sysctl_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int IDXW = $clog2(NREG);

    // Status bit positions
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_EIE = 16;

    // Register indices whose behaviour is special
    localparam int R_STATUS = 12;
    localparam int R_EPC    = 14;
    localparam int R_COND   = 21;
    localparam int R_PERF   = 25;
    localparam int R_ERREPC = 30;

    localparam logic [XLEN-1:0] PERF_CTL_MASK = 32'h800F_FBFE;
    localparam logic [XLEN-1:0] STATUS_RESET  = 32'h0000_0004;

    typedef enum logic [3:0] {
        OP_NONE, OP_READ, OP_WRITE, OP_BR_Z, OP_BR_NZ, OP_BR_ZL,
        OP_TLBWI, OP_ERET, OP_EI, OP_DI, OP_ILLEGAL
    } cop_op_e;
endpackage

// File: rtl/sysctl_decode.sv
// Instruction decoder: turns the format, rt and function fields into one
// operation code. Assumes the caller gates nothing; valid low yields OP_NONE.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic       valid_i,
    input  logic [4:0] fmt_i,
    input  logic [4:0] rt_i,
    input  logic [5:0] func_i,
    output cop_op_e    op_o
);
    // Select the operation from the format, then from rt or function bits
    always_comb begin
        op_o = OP_ILLEGAL;
        if (!valid_i) begin
            op_o = OP_NONE;
        end else begin
            case (fmt_i)
                5'd0:  op_o = OP_READ;
                5'd4:  op_o = OP_WRITE;
                5'd8: begin
                    case (rt_i)
                        5'd0:    op_o = OP_BR_Z;
                        5'd1:    op_o = OP_BR_NZ;
                        5'd2:    op_o = OP_BR_ZL;
                        default: op_o = OP_ILLEGAL;
                    endcase
                end
                5'd16: begin
                    case (func_i)
                        6'h02:   op_o = OP_TLBWI;
                        6'h18:   op_o = OP_ERET;
                        6'h38:   op_o = OP_EI;
                        6'h39:   op_o = OP_DI;
                        default: op_o = OP_ILLEGAL;
                    endcase
                end
                default: op_o = OP_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
// Control register storage: a bank of NREG registers, one counter-control
// register and NCNT counter registers. It has one bank write port and one
// combinational read port. Index R_PERF of the read port is routed to the
// counter-control register or to a counter. Bank entry R_PERF is never written.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int N     = NREG,
    parameter int NCNT  = 2,
    localparam int IW   = $clog2(N),
    localparam int CW   = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          ctl_wr_i,
    input  logic          cnt_wr_i,
    input  logic [CW-1:0] cnt_idx_i,
    input  logic [W-1:0]  perf_data_i,
    input  logic [IW-1:0] rd_idx_i,
    input  logic          rd_cnt_sel_i,
    output logic [W-1:0]  rd_data_o,
    output logic [W-1:0]  status_o,
    output logic [W-1:0]  epc_o,
    output logic [W-1:0]  errepc_o,
    output logic [W-1:0]  cond_o
);
    logic [W-1:0] bank [N];
    logic [W-1:0] cnt  [NCNT];
    logic [W-1:0] ctl_q;

    for (genvar i = 0; i < N; i++) begin : g_bank
        localparam logic [W-1:0] RST_VAL = (i == R_STATUS) ? W'(STATUS_RESET) : '0;
        // Hold one control register; load it on a matching write
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                bank[i] <= RST_VAL;
            else if (wr_en_i && wr_idx_i == IW'(i))
                bank[i] <= wr_data_i;
        end
    end

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        // Hold one counter register; load it on a matching write
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                cnt[c] <= '0;
            else if (cnt_wr_i && cnt_idx_i == CW'(c))
                cnt[c] <= perf_data_i;
        end
    end

    // Hold the counter-control register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            ctl_q <= '0;
        else if (ctl_wr_i)
            ctl_q <= perf_data_i;
    end

    // Read port: index R_PERF is routed to the counter block
    always_comb begin
        if (rd_idx_i == IW'(R_PERF))
            rd_data_o = rd_cnt_sel_i ? cnt[cnt_idx_i] : ctl_q;
        else
            rd_data_o = bank[rd_idx_i];
    end

    assign status_o = bank[R_STATUS];
    assign epc_o    = bank[R_EPC];
    assign errepc_o = bank[R_ERREPC];
    assign cond_o   = bank[R_COND];
endmodule

// File: rtl/sysctl_cop.sv
// System control coprocessor top. Executes one coprocessor-0 instruction per
// valid cycle. Its outputs are combinational from the current state, and state
// changes land on the next edge. Assumes the caller holds the instruction
// stable for the whole cycle.
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int NCNT = 2,
    localparam int CW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   gpr_i,
    input  logic              mode64_i,
    output logic [2*XLEN-1:0] rd_data_o,
    output logic              branch_taken_o,
    output logic              annul_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              eret_o,
    output logic              irq_recheck_o,
    output logic              illegal_o
);
    cop_op_e         op;
    logic [IDXW-1:0] rd_idx;
    logic            wr_en, ctl_wr, cnt_wr;
    logic [XLEN-1:0] wr_data, perf_data, rd_val;
    logic [XLEN-1:0] status_w, epc_w, errepc_w, cond_w;
    logic [IDXW-1:0] wr_idx;

    assign rd_idx = instr_i[15:11];

    sysctl_decode u_dec (
        .valid_i (valid_i),
        .fmt_i   (instr_i[25:21]),
        .rt_i    (instr_i[20:16]),
        .func_i  (instr_i[5:0]),
        .op_o    (op)
    );

    sysctl_regs #(.W(XLEN), .N(NREG), .NCNT(NCNT)) u_regs (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .wr_en_i      (wr_en),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .ctl_wr_i     (ctl_wr),
        .cnt_wr_i     (cnt_wr),
        .cnt_idx_i    (instr_i[CW:1]),
        .perf_data_i  (perf_data),
        .rd_idx_i     (rd_idx),
        .rd_cnt_sel_i (instr_i[0]),
        .rd_data_o    (rd_val),
        .status_o     (status_w),
        .epc_o        (epc_w),
        .errepc_o     (errepc_w),
        .cond_o       (cond_w)
    );

    // Execute the decoded operation: result flags and register updates
    always_comb begin
        rd_data_o        = '0;
        branch_taken_o   = 1'b0;
        annul_o          = 1'b0;
        redirect_valid_o = 1'b0;
        redirect_pc_o    = '0;
        eret_o           = 1'b0;
        irq_recheck_o    = 1'b0;
        illegal_o        = 1'b0;
        wr_en            = 1'b0;
        wr_idx           = IDXW'(R_STATUS);
        wr_data          = status_w;
        ctl_wr           = 1'b0;
        cnt_wr           = 1'b0;
        perf_data        = gpr_i;
        case (op)
            OP_READ: begin
                rd_data_o = mode64_i ? {{XLEN{rd_val[XLEN-1]}}, rd_val}
                                     : {{XLEN{1'b0}}, rd_val};
            end
            OP_WRITE: begin
                if (rd_idx == IDXW'(R_PERF)) begin
                    if (instr_i[0])
                        cnt_wr = 1'b1;
                    else if (instr_i[5:1] == 5'd0) begin
                        ctl_wr    = 1'b1;
                        perf_data = gpr_i & PERF_CTL_MASK;
                    end
                end else begin
                    wr_en  = 1'b1;
                    wr_idx = rd_idx;
                    if (rd_idx == IDXW'(R_STATUS))
                        wr_data = gpr_i | (status_w & (XLEN'(1) << ST_EXL));
                    else
                        wr_data = gpr_i;
                end
            end
            OP_BR_Z:  branch_taken_o = (cond_w == '0);
            OP_BR_NZ: branch_taken_o = (cond_w != '0);
            OP_BR_ZL: begin
                branch_taken_o = (cond_w == '0);
                annul_o        = (cond_w != '0);
            end
            OP_ERET: begin
                redirect_valid_o = 1'b1;
                eret_o           = 1'b1;
                wr_en            = 1'b1;
                if (status_w[ST_ERL]) begin
                    redirect_pc_o = errepc_w;
                    wr_data       = status_w & ~(XLEN'(1) << ST_ERL);
                end else begin
                    redirect_pc_o = epc_w;
                    wr_data       = status_w & ~(XLEN'(1) << ST_EXL);
                end
            end
            OP_EI: begin
                wr_en         = 1'b1;
                wr_data       = status_w | (XLEN'(1) << ST_EIE);
                irq_recheck_o = 1'b1;
            end
            OP_DI: begin
                wr_en   = 1'b1;
                wr_data = status_w & ~(XLEN'(1) << ST_EIE);
            end
            OP_ILLEGAL: illegal_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sysctl_cop_chk.sv
// Property checker for sysctl_cop, attached by bind. It observes the ports
// and the Status value that the register block drives.
module sysctl_cop_chk (
    input logic        clk_i,
    input logic        rst_n_i,
    input logic        valid_i,
    input logic [31:0] instr_i,
    input logic        mode64_i,
    input logic [31:0] status_i,
    input logic [63:0] rd_data_i,
    input logic        taken_i,
    input logic        annul_i,
    input logic        redir_i,
    input logic        eret_i,
    input logic        recheck_i,
    input logic        illegal_i
);
    logic is_status_wr, is_eret;
    assign is_status_wr = valid_i && instr_i[25:21] == 5'd4 && instr_i[15:11] == 5'd12;
    assign is_eret      = valid_i && instr_i[25:21] == 5'd16 && instr_i[5:0] == 6'h18;

    // R5
    exl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_status_wr && status_i[1] |=> status_i[1]);
    // R8
    erl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_eret && status_i[2] |=> !status_i[2]);
    // R9
    exl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        is_eret && !status_i[2] |=> !status_i[1] && !status_i[2]);
    // R10
    recheck_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        recheck_i |-> valid_i && instr_i[25:21] == 5'd16 && instr_i[5:0] == 6'h38);
    // R10
    eie_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        recheck_i |=> status_i[16]);
    // R7
    annul_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        annul_i |-> !taken_i);
    // R13
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !valid_i |-> !(taken_i || annul_i || redir_i || eret_i || recheck_i || illegal_i));
    // R1
    excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({taken_i, redir_i, recheck_i, illegal_i}));
    // R3
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !mode64_i |-> rd_data_i[63:32] == 32'd0);
endmodule

bind sysctl_cop sysctl_cop_chk u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .mode64_i  (mode64_i),
    .status_i  (status_w),
    .rd_data_i (rd_data_o),
    .taken_i   (branch_taken_o),
    .annul_i   (annul_o),
    .redir_i   (redirect_valid_o),
    .eret_i    (eret_o),
    .recheck_i (irq_recheck_o),
    .illegal_i (illegal_o)
);

// File: tb/sysctl_cop_tb.sv
// Bench for sysctl_cop: a vector table, then directed tests.
module sysctl_cop_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic [31:0] instr;
    logic [31:0] gpr;
    logic        m64;
    logic [63:0] rd_data;
    logic        taken, annul, redir, eret, recheck, illegal;
    logic [31:0] pc;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sysctl_cop dut_i (
        .clk_i            (clk),
        .rst_n_i          (rst_n),
        .valid_i          (valid),
        .instr_i          (instr),
        .gpr_i            (gpr),
        .mode64_i         (m64),
        .rd_data_o        (rd_data),
        .branch_taken_o   (taken),
        .annul_o          (annul),
        .redirect_valid_o (redir),
        .redirect_pc_o    (pc),
        .eret_o           (eret),
        .irq_recheck_o    (recheck),
        .illegal_o        (illegal)
    );

    // flags: {taken, annul, redirect_valid, eret, recheck, illegal}
    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] gpr;
        logic        m64;
        logic [63:0] rd;
        logic [5:0]  fl;
        logic [31:0] pc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{32'h40006000, 32'h0,        1'b0, 64'h4,                 6'b000000, 32'h0,        4'd13}, // R13 Status reset
        '{32'h40807000, 32'h80001000, 1'b0, 64'h0,                 6'b000000, 32'h0,        4'd4},  // R4 EPC
        '{32'h40007000, 32'h0,        1'b1, 64'hFFFFFFFF80001000,  6'b000000, 32'h0,        4'd3},  // R3 sign-extend
        '{32'h40007000, 32'h0,        1'b0, 64'h0000000080001000,  6'b000000, 32'h0,        4'd3},  // R3 zero upper
        '{32'h4080F000, 32'h00002000, 1'b0, 64'h0,                 6'b000000, 32'h0,        4'd4},  // R4 ErrorEPC
        '{32'h42000018, 32'h0,        1'b0, 64'h0,                 6'b001100, 32'h00002000, 4'd8},  // R8
        '{32'h40006000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd8},  // R8 ERL cleared
        '{32'h40806000, 32'h2,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd5},  // R5 set EXL
        '{32'h40806000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd5},  // R5 try clear
        '{32'h40006000, 32'h0,        1'b0, 64'h2,                 6'b000000, 32'h0,        4'd5},  // R5 EXL kept
        '{32'h42000018, 32'h0,        1'b0, 64'h0,                 6'b001100, 32'h80001000, 4'd9},  // R9
        '{32'h40006000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd9},  // R9 EXL cleared
        '{32'h42000038, 32'h0,        1'b0, 64'h0,                 6'b000010, 32'h0,        4'd10}, // R10 EI
        '{32'h40006000, 32'h0,        1'b0, 64'h10000,             6'b000000, 32'h0,        4'd10}, // R10
        '{32'h42000039, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd10}, // R10 DI
        '{32'h40006000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd10}, // R10
        '{32'h41000000, 32'h0,        1'b0, 64'h0,                 6'b100000, 32'h0,        4'd6},  // R6 zero, taken
        '{32'h41010000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd6},  // R6 nonzero, not taken
        '{32'h41020000, 32'h0,        1'b0, 64'h0,                 6'b100000, 32'h0,        4'd7},  // R7 likely taken
        '{32'h4080A800, 32'h5,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd4},  // R4 cond reg
        '{32'h41000000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd6},  // R6
        '{32'h41010000, 32'h0,        1'b0, 64'h0,                 6'b100000, 32'h0,        4'd6},  // R6
        '{32'h41020000, 32'h0,        1'b0, 64'h0,                 6'b010000, 32'h0,        4'd7},  // R7 annul
        '{32'h41030000, 32'h0,        1'b0, 64'h0,                 6'b000001, 32'h0,        4'd6},  // R6 bad rt
        '{32'h4080C800, 32'hFFFFFFFF, 1'b0, 64'h0,                 6'b000000, 32'h0,        4'd12}, // R12 masked
        '{32'h4000C800, 32'h0,        1'b0, 64'h800FFBFE,          6'b000000, 32'h0,        4'd12}, // R12
        '{32'h4080C802, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd12}, // R12 dropped
        '{32'h4000C800, 32'h0,        1'b0, 64'h800FFBFE,          6'b000000, 32'h0,        4'd12}, // R12 unchanged
        '{32'h4080C801, 32'h11,       1'b0, 64'h0,                 6'b000000, 32'h0,        4'd11}, // R11 counter 0
        '{32'h4080C803, 32'h22,       1'b0, 64'h0,                 6'b000000, 32'h0,        4'd11}, // R11 counter 1
        '{32'h4000C801, 32'h0,        1'b0, 64'h11,                6'b000000, 32'h0,        4'd11}, // R11
        '{32'h4000C803, 32'h0,        1'b0, 64'h22,                6'b000000, 32'h0,        4'd11}, // R11
        '{32'h42000002, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd2},  // R2 TLB write
        '{32'h40006000, 32'h0,        1'b0, 64'h0,                 6'b000000, 32'h0,        4'd2},  // R2 no effect
        '{32'h42000001, 32'h0,        1'b0, 64'h0,                 6'b000001, 32'h0,        4'd2}   // R2 bad code
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one instruction after the falling edge and let outputs settle
    task automatic apply(input logic v, input logic [31:0] ins,
                         input logic [31:0] g, input logic mode);
        @(negedge clk);
        valid = v; instr = ins; gpr = g; m64 = mode;
        #1;
    endtask

    function automatic logic [63:0] flags();
        return {58'd0, taken, annul, redir, eret, recheck, illegal};
    endfunction

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid = 1'b0; instr = '0; gpr = '0; m64 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R13", "flags in reset", flags(), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(1'b1, VEC[k].ins, VEC[k].gpr, VEC[k].m64);
            chk($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d rd", k), rd_data, VEC[k].rd);
            chk($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d flags", k), flags(), {58'd0, VEC[k].fl});
            chk($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d pc", k), {32'd0, pc}, {32'd0, VEC[k].pc});
        end

        // R1: every unassigned format is illegal
        for (int f = 0; f < 32; f++) begin
            if (f != 0 && f != 4 && f != 8 && f != 16) begin
                apply(1'b1, {6'h10, 5'(f), 21'd0}, 32'h0, 1'b0);
                chk("R1", $sformatf("fmt %0d illegal", f), {63'd0, illegal}, 64'd1);
            end
        end

        // R13: with valid low, an exception return is ignored
        apply(1'b1, 32'h40806000, 32'h2, 1'b0);
        apply(1'b0, 32'h42000018, 32'h0, 1'b0);
        chk("R13", "idle flags", flags(), 64'd0);
        apply(1'b1, 32'h40006000, 32'h0, 1'b0);
        chk("R13", "status untouched", rd_data, 64'h2);

        // R13: reset in mid-run restores every register
        @(negedge clk);
        valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 32'h40006000, 32'h0, 1'b0);
        chk("R13", "status after reset", rd_data, 64'h4);
        apply(1'b1, 32'h40007000, 32'h0, 1'b0);
        chk("R13", "EPC after reset", rd_data, 64'h0);
        apply(1'b1, 32'h4000C800, 32'h0, 1'b0);
        chk("R13", "ctl after reset", rd_data, 64'h0);
        apply(1'b1, 32'h4000C801, 32'h0, 1'b0);
        chk("R13", "counter after reset", rd_data, 64'h0);
        apply(1'b1, 32'h4000A800, 32'h0, 1'b0);
        chk("R13", "cond after reset", rd_data, 64'h0);
        apply(1'b0, 32'h0, 32'h0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule